// File: doc/BRIEF.md
# Edge Transition Counter with Timestamp Capture

This block is one timer channel configured as an input watcher. It looks at an already synchronized pin and detects transitions of a chosen polarity. Each accepted transition is stamped with the value of one of two 16-bit free-running time bases. It keeps a running count of accepted transitions. It also keeps two timestamps: the most recent capture, and the capture at which the count reached the programmed limit.

Reaching the limit produces a one-cycle interrupt pulse. In one-shot mode the channel then goes idle until software re-initializes it. In repeating mode the count wraps to zero and capturing goes on.

Configuration is sampled only on a one-cycle initialize strobe. That strobe clears the count and both timestamps and arms the channel. Some configuration codes mean "leave the current setting alone": an edge code with its top bit set, and a time base code outside the input-capture range. Re-initializing with those codes keeps the previous edge mode or time base.

Top module: `edge_tally_chan`

## Requirements
- R1: While reset is low, and after reset until the first initialize strobe, the count, both timestamps and the interrupt are zero, and no transition is counted.
- R2: On initialize with edge_cfg_i[2]=0, edge_cfg_i[1:0] selects the edges accepted: 00 none, 01 rising only, 10 falling only, 11 both.
- R3: On initialize with edge_cfg_i[2]=1, the edge mode already in force is kept.
- R4: On initialize with tbase_i[3:2]=00, tbase_i[1]=0 selects time base A and tbase_i[1]=1 selects time base B; any other code keeps the previous selection.
- R5: A transition is taken when pin_i at a clock edge differs from its value at the previous edge in an accepted direction. At that edge the count goes up by one and the selected time base value is stored as the last transition time.
- R6: At the edge where the count reaches the limit, the same time value is also stored as the final transition time. irq_o is high for exactly the following cycle.
- R7: In one-shot mode (repeat_i=0 at initialize), the count holds the limit after the interrupt, and later transitions change nothing until the next initialize.
- R8: In repeating mode (repeat_i=1 at initialize), the count returns to 0 when the limit is reached and capturing continues.
- R9: A limit of 0 behaves as a limit of 1.
- R10: Initialize clears the count and both timestamps and arms the channel. A transition at the same edge as initialize is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Synchronized channel pin |
| base_a_i | input | 16 | Time base A value |
| base_b_i | input | 16 | Time base B value |
| init_i | input | 1 | Initialize strobe, samples the configuration |
| edge_cfg_i | input | 3 | Edge action code (bit 2 = keep current) |
| tbase_i | input | 4 | Time base select code |
| limit_i | input | 16 | Transition count that raises the interrupt |
| repeat_i | input | 1 | 1 = repeating, 0 = one-shot |
| count_o | output | 16 | Transitions counted |
| last_time_o | output | 16 | Time of the latest counted transition |
| final_time_o | output | 16 | Time of the transition that reached the limit |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Some properties are checked on every cycle: the count only ever steps by one or drops to zero, the interrupt never lasts more than a cycle, the two timestamps agree while the interrupt is high, and everything is clear one cycle after initialize or during reset. Other behaviour can only be shown by the bench's scenarios. That covers which edge polarities are accepted, which time base is stamped, the keep-current codes, one-shot versus repeating behaviour after the limit, and the zero limit.

// File: rtl/edge_tally_pkg.sv
package edge_tally_pkg;

   typedef enum logic [1:0] {
      EDGE_NONE = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_ANY  = 2'b11
   } edge_mode_e;

   typedef struct packed {
      edge_mode_e mode;
      logic       use_b;
      logic       rpt;
   } chan_cfg_t;

   function automatic logic edge_match(edge_mode_e m, logic prev, logic cur);
      case (m)
         EDGE_RISE: return !prev && cur;
         EDGE_FALL: return prev && !cur;
         EDGE_ANY:  return prev ^ cur;
         default:   return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/edge_tally_cfg.sv
module edge_tally_cfg
   import edge_tally_pkg::*;
#(
   parameter int CNT_W          = 16,
   parameter bit ZERO_MEANS_ONE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_i,
   input  logic [2:0]       edge_cfg_i,
   input  logic [3:0]       tbase_i,
   input  logic [CNT_W-1:0] limit_i,
   input  logic             repeat_i,
   output chan_cfg_t        cfg_o,
   output logic [CNT_W-1:0] limit_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   chan_cfg_t        cfg_q;
   logic [CNT_W-1:0] limit_q;
   logic             unused_tbase_lsb;

   assign unused_tbase_lsb = tbase_i[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= '{mode: EDGE_NONE, use_b: 1'b0, rpt: 1'b0};
         limit_q <= '0;
      end else if (init_i) begin
         if (!edge_cfg_i[2])
            cfg_q.mode <= edge_mode_e'(edge_cfg_i[1:0]);
         if (tbase_i[3:2] == 2'b00)
            cfg_q.use_b <= tbase_i[1];
         cfg_q.rpt <= repeat_i;
         limit_q   <= limit_i;
      end
   end

   assign cfg_o = cfg_q;

   generate
      if (ZERO_MEANS_ONE) begin : g_zero_one
         assign limit_o = (limit_q == '0) ? ONE : limit_q;
      end else begin : g_zero_raw
         assign limit_o = limit_q;
      end
   endgenerate

endmodule

// File: rtl/edge_tally_detect.sv
module edge_tally_detect
   import edge_tally_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  edge_mode_e mode_i,
   output logic       hit_o
);

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin_i;
   end

   assign hit_o = edge_match(mode_i, prev_q, pin_i);

endmodule

// File: rtl/edge_tally_core.sv
module edge_tally_core #(
   parameter int CNT_W  = 16,
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              init_i,
   input  logic              hit_i,
   input  logic [TIME_W-1:0] stamp_i,
   input  logic [CNT_W-1:0]  limit_i,
   input  logic              rpt_i,
   output logic [CNT_W-1:0]  count_o,
   output logic [TIME_W-1:0] last_o,
   output logic [TIME_W-1:0] final_o,
   output logic              irq_o
);

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_nxt;
   logic [TIME_W-1:0] last_q;
   logic [TIME_W-1:0] final_q;
   logic              armed_q;
   logic              irq_q;
   logic              take;
   logic              at_limit;

   assign cnt_nxt  = cnt_q + 1'b1;
   assign take     = armed_q && hit_i;
   assign at_limit = (cnt_nxt == limit_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         last_q  <= '0;
         final_q <= '0;
         armed_q <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (init_i) begin
            cnt_q   <= '0;
            last_q  <= '0;
            final_q <= '0;
            armed_q <= 1'b1;
         end else if (take) begin
            last_q <= stamp_i;
            if (at_limit) begin
               final_q <= stamp_i;
               irq_q   <= 1'b1;
               if (rpt_i) begin
                  cnt_q <= '0;
               end else begin
                  cnt_q   <= cnt_nxt;
                  armed_q <= 1'b0;
               end
            end else begin
               cnt_q <= cnt_nxt;
            end
         end
      end
   end

   assign count_o = cnt_q;
   assign last_o  = last_q;
   assign final_o = final_q;
   assign irq_o   = irq_q;

endmodule

// File: rtl/edge_tally_chan.sv
module edge_tally_chan
   import edge_tally_pkg::*;
#(
   parameter int CNT_W          = 16,
   parameter int TIME_W         = 16,
   parameter bit ZERO_MEANS_ONE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_i,
   input  logic [TIME_W-1:0] base_a_i,
   input  logic [TIME_W-1:0] base_b_i,
   input  logic              init_i,
   input  logic [2:0]        edge_cfg_i,
   input  logic [3:0]        tbase_i,
   input  logic [CNT_W-1:0]  limit_i,
   input  logic              repeat_i,
   output logic [CNT_W-1:0]  count_o,
   output logic [TIME_W-1:0] last_time_o,
   output logic [TIME_W-1:0] final_time_o,
   output logic              irq_o
);

   initial begin
      if (CNT_W < 2)  $error("edge_tally_chan: CNT_W must be at least 2");
      if (TIME_W < 2) $error("edge_tally_chan: TIME_W must be at least 2");
   end

   chan_cfg_t         cfg;
   logic [CNT_W-1:0]  limit_eff;
   logic              hit;
   logic [TIME_W-1:0] stamp;

   edge_tally_cfg #(
      .CNT_W         (CNT_W),
      .ZERO_MEANS_ONE(ZERO_MEANS_ONE)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_i    (init_i),
      .edge_cfg_i(edge_cfg_i),
      .tbase_i   (tbase_i),
      .limit_i   (limit_i),
      .repeat_i  (repeat_i),
      .cfg_o     (cfg),
      .limit_o   (limit_eff)
   );

   edge_tally_detect u_det (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (pin_i),
      .mode_i(cfg.mode),
      .hit_o (hit)
   );

   assign stamp = cfg.use_b ? base_b_i : base_a_i;

   edge_tally_core #(
      .CNT_W (CNT_W),
      .TIME_W(TIME_W)
   ) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .init_i (init_i),
      .hit_i  (hit),
      .stamp_i(stamp),
      .limit_i(limit_eff),
      .rpt_i  (cfg.rpt),
      .count_o(count_o),
      .last_o (last_time_o),
      .final_o(final_time_o),
      .irq_o  (irq_o)
   );

endmodule

// File: rtl/edge_tally_chk.sv
module edge_tally_chk #(
   parameter int CNT_W  = 16,
   parameter int TIME_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              init_i,
   input logic [CNT_W-1:0]  count_o,
   input logic [TIME_W-1:0] last_time_o,
   input logic [TIME_W-1:0] final_time_o,
   input logic              irq_o
);

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (count_o == '0 && !irq_o));

   assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(count_o) |-> (count_o == $past(count_o) + 1'b1) || (count_o == '0));

   assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   assert_irq_times_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (last_time_o == final_time_o));

   assert_init_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(init_i) |-> (count_o == '0 && last_time_o == '0 && final_time_o == '0 && !irq_o));

endmodule

bind edge_tally_chan edge_tally_chk #(
   .CNT_W (CNT_W),
   .TIME_W(TIME_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .init_i      (init_i),
   .count_o     (count_o),
   .last_time_o (last_time_o),
   .final_time_o(final_time_o),
   .irq_o       (irq_o)
);

// File: tb/edge_tally_chan_tb_top.sv
module edge_tally_chan_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin_i = 1'b0;
   logic [15:0] base_a_i = '0;
   logic [15:0] base_b_i = '0;
   logic        init_i = 1'b0;
   logic [2:0]  edge_cfg_i = '0;
   logic [3:0]  tbase_i = '0;
   logic [15:0] limit_i = '0;
   logic        repeat_i = 1'b0;
   logic [15:0] count_o;
   logic [15:0] last_time_o;
   logic [15:0] final_time_o;
   logic        irq_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   edge_tally_chan dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .pin_i       (pin_i),
      .base_a_i    (base_a_i),
      .base_b_i    (base_b_i),
      .init_i      (init_i),
      .edge_cfg_i  (edge_cfg_i),
      .tbase_i     (tbase_i),
      .limit_i     (limit_i),
      .repeat_i    (repeat_i),
      .count_o     (count_o),
      .last_time_o (last_time_o),
      .final_time_o(final_time_o),
      .irq_o       (irq_o)
   );

   typedef struct packed {
      logic        ini;
      logic [2:0]  ecfg;
      logic [3:0]  tbs;
      logic [15:0] lim;
      logic        rpt;
      logic        pin;
      logic [15:0] ta;
      logic [15:0] tb;
      logic [15:0] ecnt;
      logic [15:0] elast;
      logic [15:0] efin;
      logic        eirq;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      // R10 init, rising only, base A, limit 3, one-shot
      '{1'b1, 3'b001, 4'b0000, 16'd3, 1'b0, 1'b0, 16'd10,  16'd0,   16'd0, 16'd0,   16'd0,   1'b0},
      '{1'b0, 3'b001, 4'b0000, 16'd3, 1'b0, 1'b1, 16'd20,  16'd0,   16'd1, 16'd20,  16'd0,   1'b0}, // R5
      '{1'b0, 3'b001, 4'b0000, 16'd3, 1'b0, 1'b0, 16'd30,  16'd0,   16'd1, 16'd20,  16'd0,   1'b0}, // R2 fall ignored
      '{1'b0, 3'b001, 4'b0000, 16'd3, 1'b0, 1'b1, 16'd40,  16'd0,   16'd2, 16'd40,  16'd0,   1'b0},
      '{1'b0, 3'b001, 4'b0000, 16'd3, 1'b0, 1'b0, 16'd50,  16'd0,   16'd2, 16'd40,  16'd0,   1'b0},
      '{1'b0, 3'b001, 4'b0000, 16'd3, 1'b0, 1'b1, 16'd60,  16'd0,   16'd3, 16'd60,  16'd60,  1'b1}, // R6
      '{1'b0, 3'b001, 4'b0000, 16'd3, 1'b0, 1'b0, 16'd70,  16'd0,   16'd3, 16'd60,  16'd60,  1'b0},
      '{1'b0, 3'b001, 4'b0000, 16'd3, 1'b0, 1'b1, 16'd80,  16'd0,   16'd3, 16'd60,  16'd60,  1'b0}, // R7
      // R10 re-init: both edges, base B, limit 2, repeating
      '{1'b1, 3'b011, 4'b0010, 16'd2, 1'b1, 1'b1, 16'd90,  16'd500, 16'd0, 16'd0,   16'd0,   1'b0},
      '{1'b0, 3'b011, 4'b0010, 16'd2, 1'b1, 1'b0, 16'd91,  16'd510, 16'd1, 16'd510, 16'd0,   1'b0}, // R4 base B
      '{1'b0, 3'b011, 4'b0010, 16'd2, 1'b1, 1'b1, 16'd92,  16'd520, 16'd0, 16'd520, 16'd520, 1'b1}, // R8
      '{1'b0, 3'b011, 4'b0010, 16'd2, 1'b1, 1'b0, 16'd93,  16'd530, 16'd1, 16'd530, 16'd520, 1'b0}, // R8
      // R3/R4 keep codes, R9 limit 0, R10 edge at init not counted
      '{1'b1, 3'b101, 4'b0100, 16'd0, 1'b0, 1'b1, 16'd1,   16'd540, 16'd0, 16'd0,   16'd0,   1'b0},
      '{1'b0, 3'b101, 4'b0100, 16'd0, 1'b0, 1'b0, 16'd1,   16'd550, 16'd1, 16'd550, 16'd550, 1'b1},
      '{1'b0, 3'b101, 4'b0100, 16'd0, 1'b0, 1'b1, 16'd1,   16'd560, 16'd1, 16'd550, 16'd550, 1'b0},
      // R2 code 00 detects nothing
      '{1'b1, 3'b000, 4'b0000, 16'd5, 1'b0, 1'b1, 16'd7,   16'd0,   16'd0, 16'd0,   16'd0,   1'b0},
      '{1'b0, 3'b000, 4'b0000, 16'd5, 1'b0, 1'b0, 16'd8,   16'd0,   16'd0, 16'd0,   16'd0,   1'b0},
      '{1'b0, 3'b000, 4'b0000, 16'd5, 1'b0, 1'b1, 16'd9,   16'd0,   16'd0, 16'd0,   16'd0,   1'b0}
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req, input int c, input int l, input int f, input int q);
      chk(req, "count", int'(count_o), c);
      chk(req, "last_time", int'(last_time_o), l);
      chk(req, "final_time", int'(final_time_o), f);
      chk(req, "irq", int'(irq_o), q);
   endtask

   task automatic drive(input vec_t v);
      init_i     = v.ini;
      edge_cfg_i = v.ecfg;
      tbase_i    = v.tbs;
      limit_i    = v.lim;
      repeat_i   = v.rpt;
      pin_i      = v.pin;
      base_a_i   = v.ta;
      base_b_i   = v.tb;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk_all("R1", 0, 0, 0, 0);  // R1 during reset
      rst_n = 1'b1;
      // R1: toggling before any init is not counted
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         pin_i    = ~pin_i;
         base_a_i = 16'(k + 100);
      end
      @(negedge clk);
      chk_all("R1", 0, 0, 0, 0);
      pin_i = 1'b0;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         @(negedge clk);
         chk_all($sformatf("vec%0d", i), int'(VECS[i].ecnt), int'(VECS[i].elast),
                 int'(VECS[i].efin), int'(VECS[i].eirq));
      end
      init_i = 1'b0;

      // R1: reset in the middle of a run clears everything
      drive('{1'b1, 3'b011, 4'b0000, 16'd9, 1'b0, 1'b0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 1'b0});
      @(negedge clk);
      init_i = 1'b0; pin_i = 1'b1; base_a_i = 16'd33;
      @(negedge clk);
      chk("R5", "count before reset", int'(count_o), 1);
      rst_n = 1'b0;
      @(negedge clk);
      chk_all("R1", 0, 0, 0, 0);
      rst_n = 1'b1;
      pin_i = 1'b0;
      @(negedge clk);
      pin_i = 1'b1;
      @(negedge clk);
      chk_all("R1", 0, 0, 0, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule